// File: doc/BRIEF.md
# Record and Replay Mode Sequencer

This block is the mode sequencer of a data recorder. It holds the recorder in one of three modes: a quiet retention mode in which nothing is accessed, a recording mode in which every incoming sample is written to the next memory location, and a replay mode in which the stored words are read back and streamed out. While recording, it strobes the chip select of the external write address generator, which steps on each write. It also issues a clear to that generator when a recording starts. While replaying, it generates the read address itself.

A replay is started in one of three ways. A request can interrupt a recording. The frame counter can reach its full value. A power-on request can start a replay from retention without any recording first. Each replay pass begins with a two-byte marker word, high byte first, followed by the stored words from address zero up to an end address. The passes repeat until a stop command returns the block to retention. Chip selects are raised only in the cycles in which a real memory access takes place.

Top module: `recplay_ctrl`

## Requirements
- R1: While reset is applied, mode is retention (code 0), wrClr, wrCs, rdCs and outValid are low, and rdAddr is 0.
- R2: storeCmd in retention raises wrClr in that same cycle, and mode becomes recording (code 1) on the next cycle. storeCmd has priority over powerOnReq.
- R3: In recording mode, wrCs is high exactly in the cycles where sampleValid is high and no stop, replay or full condition is present. rdCs stays low.
- R4: replayReq in recording mode switches mode to replay (code 2) on the next cycle. The pass end address is wrAddr-1, or 0 when wrAddr is 0.
- R5: In recording mode, frameCnt >= FULL_FRAMES starts replay with end address 2^ADDR_W-1. This takes precedence over replayReq.
- R6: powerOnReq in retention starts replay with end address 2^ADDR_W-1, with no recording before it.
- R7: A replay pass emits the marker MARKER (default 16'hC3A5) as two bytes, high byte first. It then emits the memory words from address 0 to the end address in order. Each word appears on outData with outValid high one cycle after its read cycle, or after its marker cycle for the marker bytes.
- R8: After the read of the end address, the next pass starts at once with the marker and address 0. Passes repeat without limit.
- R9: rdCs is high only in replay read cycles, and wrCs only in recording cycles. Both are low in retention.
- R10: stopCmd in recording or replay returns mode to retention on the next cycle. No memory access takes place in the cycle of the stop. stopCmd has the highest priority.
- R11: In retention, rdAddr holds its value. replayReq is ignored in retention, and storeCmd and replayReq are ignored during replay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| storeCmd | input | 1 | Start a recording (pulse) |
| replayReq | input | 1 | Interrupt a recording and replay (pulse) |
| powerOnReq | input | 1 | Replay the full memory from retention (pulse) |
| stopCmd | input | 1 | Return to retention |
| sampleValid | input | 1 | A sample is ready to be stored |
| wrAddr | input | ADDR_W | Current value of the external write address generator |
| frameCnt | input | FCNT_W | Recorded frame count |
| memRdData | input | 8 | Memory read data, valid one cycle after rdCs |
| mode | output | 2 | 0 retention, 1 recording, 2 replay |
| wrClr | output | 1 | Clear the write address generator |
| wrCs | output | 1 | Memory write select, which also steps the write generator |
| rdCs | output | 1 | Memory read select |
| rdAddr | output | ADDR_W | Memory read address |
| outValid | output | 1 | Replay stream word valid |
| outData | output | 8 | Replay stream word (marker byte or memory data) |

## Verification
The bench builds the block with ADDR_W=4, FCNT_W=4 and FULL_FRAMES=3. A full-memory pass therefore lasts only 18 cycles, so several wrap-arounds of R8 fit into a short run. The small frame count limit lets the full condition be raised directly and collided with a replay request in the same cycle. With a 16-word memory, the bench covers an interrupted pass ending at address 4, a one-word pass after a recording with no writes, and full-depth passes started by both the full condition and power-on.

// File: rtl/recplay_pkg.sv
package recplay_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_STORE  = 2'd1,
    MODE_REPLAY = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    PH_MHI  = 2'd0,
    PH_MLO  = 2'd1,
    PH_READ = 2'd2
  } phase_e;

  typedef struct packed {
    logic loadEnd;
    logic endFull;
    logic clrRd;
    logic stepRd;
    logic readEn;
    logic emitHi;
    logic emitLo;
  } dp_ctl_t;
endpackage

// File: rtl/recplay_ctl.sv
module recplay_ctl
  import recplay_pkg::*;
#(
  parameter int FCNT_W      = 8,
  parameter int FULL_FRAMES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              storeCmd,
  input  logic              replayReq,
  input  logic              powerOnReq,
  input  logic              stopCmd,
  input  logic              sampleValid,
  input  logic [FCNT_W-1:0] frameCnt,
  input  logic              atEnd,
  output dp_ctl_t           ctl,
  output mode_e             state,
  output logic              wrClr,
  output logic              wrCs
);
  localparam logic [FCNT_W-1:0] FULL_CNT = FCNT_W'(FULL_FRAMES);

  mode_e  stateNxt;
  phase_e phase, phaseNxt;
  logic   memFull;

  assign memFull = (frameCnt >= FULL_CNT);

  always_comb begin
    stateNxt = state;
    phaseNxt = phase;
    ctl      = '0;
    wrClr    = 1'b0;
    wrCs     = 1'b0;
    unique case (state)
      MODE_IDLE: begin
        if (storeCmd) begin
          wrClr    = 1'b1;
          stateNxt = MODE_STORE;
        end else if (powerOnReq) begin
          stateNxt    = MODE_REPLAY;
          phaseNxt    = PH_MHI;
          ctl.loadEnd = 1'b1;
          ctl.endFull = 1'b1;
        end
      end
      MODE_STORE: begin
        if (stopCmd) begin
          stateNxt = MODE_IDLE;
        end else if (memFull) begin
          stateNxt    = MODE_REPLAY;
          phaseNxt    = PH_MHI;
          ctl.loadEnd = 1'b1;
          ctl.endFull = 1'b1;
        end else if (replayReq) begin
          stateNxt    = MODE_REPLAY;
          phaseNxt    = PH_MHI;
          ctl.loadEnd = 1'b1;
        end else begin
          wrCs = sampleValid;
        end
      end
      MODE_REPLAY: begin
        if (stopCmd) begin
          stateNxt = MODE_IDLE;
        end else begin
          unique case (phase)
            PH_MHI: begin
              ctl.emitHi = 1'b1;
              ctl.clrRd  = 1'b1;
              phaseNxt   = PH_MLO;
            end
            PH_MLO: begin
              ctl.emitLo = 1'b1;
              phaseNxt   = PH_READ;
            end
            default: begin
              ctl.readEn = 1'b1;
              if (atEnd) phaseNxt = PH_MHI;
              else       ctl.stepRd = 1'b1;
            end
          endcase
        end
      end
      default: stateNxt = MODE_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= MODE_IDLE;
      phase <= PH_MHI;
    end else begin
      state <= stateNxt;
      phase <= phaseNxt;
    end
  end

  // R2: a clear always leads into recording
  a_r2_clr_enters_store: assert property (@(posedge clk) disable iff (!rstN)
    wrClr |=> (state == MODE_STORE));

  // R4: an interrupting request starts a pass at the high marker byte
  a_r4_interrupt_to_replay: assert property (@(posedge clk) disable iff (!rstN)
    (state == MODE_STORE && replayReq && !stopCmd) |=> (state == MODE_REPLAY && phase == PH_MHI));

  // R10: stop wins over everything
  a_r10_stop_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    (stopCmd && state != MODE_IDLE) |=> (state == MODE_IDLE));

  // R3: writes only while recording with a sample present
  a_r3_write_in_store: assert property (@(posedge clk) disable iff (!rstN)
    wrCs |-> (state == MODE_STORE && sampleValid));
endmodule

// File: rtl/recplay_dp.sv
module recplay_dp
  import recplay_pkg::*;
#(
  parameter int          ADDR_W = 6,
  parameter logic [15:0] MARKER = 16'hC3A5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctl_t           ctl,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] memRdData,
  output logic              atEnd,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              outValid,
  output logic [BYTE_W-1:0] outData
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

  logic [ADDR_W-1:0] rdAddrQ, endQ, lastWr;
  logic              outIsMemQ;
  logic [BYTE_W-1:0] outByteQ;

  assign lastWr = (wrAddr == '0) ? '0 : wrAddr - ADDR_W'(1);
  assign atEnd  = (rdAddrQ == endQ);
  assign rdAddr = rdAddrQ;
  assign outData = outIsMemQ ? memRdData : outByteQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdAddrQ   <= '0;
      endQ      <= '0;
      outValid  <= 1'b0;
      outIsMemQ <= 1'b0;
      outByteQ  <= '0;
    end else begin
      if (ctl.loadEnd) endQ <= ctl.endFull ? TOP_ADDR : lastWr;
      if (ctl.clrRd)       rdAddrQ <= '0;
      else if (ctl.stepRd) rdAddrQ <= rdAddrQ + ADDR_W'(1);
      outValid  <= ctl.emitHi | ctl.emitLo | ctl.readEn;
      outIsMemQ <= ctl.readEn;
      outByteQ  <= ctl.emitHi ? MARKER[15:8] : MARKER[7:0];
    end
  end

  // R7: every emit or read is followed by a valid stream word
  a_r7_emit_valid: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.emitHi || ctl.emitLo || ctl.readEn) |=> outValid);

  // R11: the read address moves only on a replay strobe
  a_r11_addr_moves_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdAddrQ) |-> $past(ctl.clrRd || ctl.stepRd));

  // R8: the end of a pass holds the address for the next marker
  a_r8_end_no_step: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.readEn && atEnd) |=> $stable(rdAddrQ));
endmodule

// File: rtl/recplay_ctrl.sv
module recplay_ctrl
  import recplay_pkg::*;
#(
  parameter int          ADDR_W      = 6,
  parameter int          FCNT_W      = 8,
  parameter int          FULL_FRAMES = 32,
  parameter logic [15:0] MARKER      = 16'hC3A5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              storeCmd,
  input  logic              replayReq,
  input  logic              powerOnReq,
  input  logic              stopCmd,
  input  logic              sampleValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [FCNT_W-1:0] frameCnt,
  input  logic [7:0]        memRdData,
  output logic [1:0]        mode,
  output logic              wrClr,
  output logic              wrCs,
  output logic              rdCs,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              outValid,
  output logic [7:0]        outData
);
  dp_ctl_t ctl;
  mode_e   state;
  logic    atEnd;

  recplay_ctl #(.FCNT_W(FCNT_W), .FULL_FRAMES(FULL_FRAMES)) uCtl (
    .clk(clk), .rstN(rstN), .storeCmd(storeCmd), .replayReq(replayReq),
    .powerOnReq(powerOnReq), .stopCmd(stopCmd), .sampleValid(sampleValid),
    .frameCnt(frameCnt), .atEnd(atEnd), .ctl(ctl), .state(state),
    .wrClr(wrClr), .wrCs(wrCs)
  );

  recplay_dp #(.ADDR_W(ADDR_W), .MARKER(MARKER)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrAddr(wrAddr), .memRdData(memRdData),
    .atEnd(atEnd), .rdAddr(rdAddr), .outValid(outValid), .outData(outData)
  );

  assign mode = state;
  assign rdCs = ctl.readEn;

  // R9: never read and write in the same cycle
  a_r9_cs_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(rdCs && wrCs));

  // R9: retention is silent on both selects
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0) |-> (!rdCs && !wrCs));
endmodule

// File: tb/tb_recplay_ctrl.sv
`timescale 1ns/1ps
module tb_recplay_ctrl;
  localparam int AW = 4;
  localparam int FW = 4;
  localparam int FULLF = 3;
  localparam int DEPTH = 1 << AW;
  localparam logic [15:0] MK = 16'hC3A5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic storeCmd = 0, replayReq = 0, powerOnReq = 0, stopCmd = 0, sampleValid = 0;
  logic [FW-1:0] frameCnt = '0;
  logic [7:0] wrData = '0;
  logic [AW-1:0] genA = '0;
  logic [7:0] memRdData = '0;
  logic [7:0] envMem [DEPTH];
  logic [1:0] mode;
  logic wrClr, wrCs, rdCs, outValid;
  logic [AW-1:0] rdAddr;
  logic [7:0] outData;

  int total = 0, bad = 0;
  string curReq = "R1";

  // reference model state
  int mSt = 0, mSub = 0, mRd = 0, mEnd = 0, mGen = 0, mOV = 0, mOD = 0;
  int expMem [DEPTH];

  always #4 clk = ~clk;

  recplay_ctrl #(.ADDR_W(AW), .FCNT_W(FW), .FULL_FRAMES(FULLF), .MARKER(MK)) dut (
    .clk(clk), .rstN(rstN), .storeCmd(storeCmd), .replayReq(replayReq),
    .powerOnReq(powerOnReq), .stopCmd(stopCmd), .sampleValid(sampleValid),
    .wrAddr(genA), .frameCnt(frameCnt), .memRdData(memRdData), .mode(mode),
    .wrClr(wrClr), .wrCs(wrCs), .rdCs(rdCs), .rdAddr(rdAddr),
    .outValid(outValid), .outData(outData)
  );

  // environment: write address generator and memory
  always @(posedge clk) begin
    if (wrClr) genA <= '0;
    else if (wrCs) begin
      envMem[genA] <= wrData;
      genA <= genA + 1'b1;
    end
    if (rdCs) memRdData <= envMem[rdAddr];
  end

  task automatic check(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", curReq, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit sC, input bit rR, input bit pO, input bit sT,
                     input bit sV, input int fc, input int wd);
    int eClr, eWr, eRd, nSt, nSub, nRd, nEnd, nOV, nOD;
    @(negedge clk);
    storeCmd = sC; replayReq = rR; powerOnReq = pO; stopCmd = sT;
    sampleValid = sV; frameCnt = FW'(fc); wrData = 8'(wd);
    #1;
    eClr = 0; eWr = 0; eRd = 0; nSt = mSt; nSub = mSub; nRd = mRd;
    nEnd = mEnd; nOV = 0; nOD = 0;
    if (mSt == 0) begin
      if (sC) begin eClr = 1; nSt = 1; end
      else if (pO) begin nSt = 2; nSub = 0; nEnd = DEPTH - 1; end
    end else if (mSt == 1) begin
      if (sT) nSt = 0;
      else if (fc >= FULLF) begin nSt = 2; nSub = 0; nEnd = DEPTH - 1; end
      else if (rR) begin nSt = 2; nSub = 0; nEnd = (mGen == 0) ? 0 : mGen - 1; end
      else if (sV) eWr = 1;
    end else begin
      if (sT) nSt = 0;
      else if (mSub == 0) begin nRd = 0; nOV = 1; nOD = MK[15:8]; nSub = 1; end
      else if (mSub == 1) begin nOV = 1; nOD = MK[7:0]; nSub = 2; end
      else begin
        eRd = 1; nOV = 1; nOD = expMem[mRd];
        if (mRd == mEnd) nSub = 0; else nRd = mRd + 1;
      end
    end
    check("mode", int'(mode), mSt);
    check("wrClr", int'(wrClr), eClr);
    check("wrCs", int'(wrCs), eWr);
    check("rdCs", int'(rdCs), eRd);
    check("rdAddr", int'(rdAddr), mRd);
    check("outValid", int'(outValid), mOV);
    if (mOV != 0) check("outData", int'(outData), mOD);
    if (eClr != 0) mGen = 0;
    else if (eWr != 0) begin expMem[mGen] = wd & 8'hFF; mGen = (mGen + 1) % DEPTH; end
    mSt = nSt; mSub = nSub; mRd = nRd; mEnd = nEnd; mOV = nOV; mOD = nOD;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      envMem[i] = 8'(8'h80 + i);
      expMem[i] = 8'h80 + i;
    end
    // R1: reset state
    repeat (3) @(negedge clk);
    curReq = "R1";
    check("mode", int'(mode), 0);
    check("wrCs", int'(wrCs), 0);
    check("rdCs", int'(rdCs), 0);
    check("wrClr", int'(wrClr), 0);
    check("outValid", int'(outValid), 0);
    check("rdAddr", int'(rdAddr), 0);
    @(negedge clk); rstN = 1'b1;
    idle(2);

    // R11: replayReq in retention is ignored
    curReq = "R11";
    cyc(0, 1, 0, 0, 0, 0, 0);
    idle(2);

    // R2, R3: record five words with gaps
    curReq = "R2";
    cyc(1, 0, 1, 0, 0, 0, 0);
    curReq = "R3";
    cyc(0, 0, 0, 0, 1, 0, 8'h11);
    cyc(0, 0, 0, 0, 0, 0, 8'h99);
    cyc(0, 0, 0, 0, 1, 0, 8'h22);
    cyc(0, 0, 0, 0, 1, 0, 8'h33);
    cyc(0, 0, 0, 0, 0, 0, 8'h98);
    cyc(0, 0, 0, 0, 1, 0, 8'h44);
    cyc(0, 0, 0, 0, 1, 0, 8'h55);
    // R4: interrupt while a sample is waiting (not written)
    curReq = "R4";
    cyc(0, 1, 0, 0, 1, 0, 8'h66);
    // R7, R8: run more than two passes, R11 commands ignored in replay
    curReq = "R8";
    for (int i = 0; i < 20; i++) cyc((i == 5), (i == 9), 0, 0, 0, 0, 0);
    // R10: stop in replay
    curReq = "R10";
    cyc(0, 0, 0, 1, 0, 0, 0);
    // R11: address holds in retention
    curReq = "R11";
    idle(4);

    // R5: full condition beats a replay request
    curReq = "R5";
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 1, 8'hA1);
    cyc(0, 0, 0, 0, 1, 2, 8'hA2);
    cyc(0, 1, 0, 0, 1, 3, 8'hA3);
    curReq = "R7";
    for (int i = 0; i < 40; i++) cyc(0, 0, 0, 0, 0, 3, 0);
    curReq = "R10";
    cyc(0, 0, 0, 1, 0, 0, 0);
    idle(2);

    // R6: power-on replay of the full memory
    curReq = "R6";
    cyc(0, 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 22; i++) cyc(0, 0, 0, 0, 0, 0, 0);
    curReq = "R10";
    cyc(0, 0, 0, 1, 0, 0, 0);
    idle(2);

    // R4: interrupt with nothing written gives a one-word pass
    curReq = "R4";
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0, 0);
    curReq = "R8";
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 0);

    // R10: stop during recording suppresses the pending write
    curReq = "R10";
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 8'h5A);
    cyc(0, 1, 0, 1, 1, 0, 8'h5B);
    idle(3);
    // R9: retention stays quiet, replay of the stored word follows
    curReq = "R9";
    cyc(0, 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 0);
    idle(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule